// File: doc/BRIEF.md
# CDS Sampling Clock Generator

This block derives the three timing lines needed by a CCD or CIS analog front end from one fast master clock. The lines are a reference-level sampling clock, a data-level sampling clock and a converter clock. A falling edge of the reference line captures the sensor's reset (reference) level, and the input clamp is active while that line is high. A falling edge of the data line captures the video level. The converter clock steps the shared converter through the colour channels.

The block has four operating modes, formed from two choices. The pixel is either three converter periods long (one per colour) or one converter period long. Sampling is either correlated double sampling, where both sampling lines toggle, or plain sample-and-hold, where the reference line stays low. All edge positions are given in master clock ticks from the start of a pixel, and each pixel has a one-cycle strobe.

A new setting is checked against the edge-ordering rules when it is loaded. A setting that breaks a rule is refused and flagged, and the running timing continues unchanged. An accepted setting takes effect only at the next pixel boundary.

Top module: `cdsclk_gen`

## Requirements
- R1: While `rst_n` is low, `ref_clk`, `dat_clk`, `cnv_clk`, `pix_start` and `cfg_err` are all 0.
- R2: After reset is released, the first pixel starts at tick 0 with the built-in setting (period 8, three-channel, double sampling, reference window ticks 0..1, data window ticks 2..4). The outputs for tick k appear after master edge k+1. With this setting, `ref_clk` is 1 after the first edge and the first `pix_start` comes after edge 5.
- R3: Let P be the converter period in ticks. `cnv_clk` is low for the first floor(P/2) ticks of each converter period and high for the rest. A pixel spans 3 converter periods when `cfg_three`=1 and 1 period when it is 0.
- R4: In double-sampling mode (`cfg_cds`=1), `ref_clk` is high exactly on ticks `ref_rise` <= s < `ref_fall` of the first converter period of each pixel, and low otherwise.
- R5: `dat_clk` is high exactly on ticks `dat_rise` <= s < `dat_fall` of the first converter period of each pixel, and low otherwise, so it is never high while `cnv_clk` is high.
- R6: In sample-and-hold mode (`cfg_cds`=0), `ref_clk` stays 0, and the reference edge fields are neither used nor checked.
- R7: `pix_start` is high for exactly one master cycle: the cycle in which `dat_clk` first reads 0 after its high phase.
- R8: A load is accepted only if all of these hold: P >= 2; `dat_rise` < `dat_fall` <= floor(P/2); and, in double-sampling mode, `ref_rise` < `ref_fall` < `dat_rise`.
- R9: After a refused load, `cfg_err` is 1 from the next cycle until the next accepted load, and the outputs keep following the previous setting.
- R10: After an accepted load, `cfg_err` is 0 from the next cycle. The new setting governs the outputs from the first pixel that starts after the load, and never part of a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that presents a new setting |
| cfg_three | input | 1 | 1: three converter periods per pixel, 0: one |
| cfg_cds | input | 1 | 1: double sampling, 0: sample-and-hold |
| cfg_period | input | 8 | Converter period P in ticks |
| cfg_ref_rise | input | 8 | Reference line rising tick |
| cfg_ref_fall | input | 8 | Reference line falling tick |
| cfg_dat_rise | input | 8 | Data line rising tick |
| cfg_dat_fall | input | 8 | Data line falling tick |
| ref_clk | output | 1 | Reference-level sampling clock |
| dat_clk | output | 1 | Data-level sampling clock |
| cnv_clk | output | 1 | Converter clock |
| pix_start | output | 1 | One-cycle pixel strobe on the data falling edge |
| cfg_err | output | 1 | Last load was refused |

## Verification
The clock lines and `pix_start` lag the internal tick counter by one register, so the outputs for tick k are sampled at the falling master edge that follows rising edge k+1. `cfg_err` is due one cycle after the load strobe, and the bench reads it at the next falling edge. A setting does not take effect until the next pixel boundary. For that reason the bench waits for two `pix_start` pulses after each load, then aligns its expected-value queue on the following `pix_start` and compares every cycle of whole pixels.

// File: rtl/cdsclk_pkg.sv
package cdsclk_pkg;
  localparam int unsigned TICK_W = 8;
  localparam int unsigned SLOT_W = 2;

  typedef logic [TICK_W-1:0] tick_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic  three;
    logic  cds;
    tick_t per;
    tick_t rr;
    tick_t rf;
    tick_t dr;
    tick_t df;
  } gen_cfg_t;

  // tick at which the converter clock turns high inside its period
  function automatic tick_t half_of(tick_t per);
    return per >> 1;
  endfunction

  // index of the final converter period inside one pixel
  function automatic slot_t last_slot(logic three);
    return three ? slot_t'(2) : slot_t'(0);
  endfunction

  function automatic logic in_win(tick_t pos, tick_t lo, tick_t hi);
    return (pos >= lo) && (pos < hi);
  endfunction

  // edge ordering rules for a candidate setting
  function automatic logic cfg_legal(gen_cfg_t c);
    logic base_ok;
    logic ref_ok;
    base_ok = (c.per >= tick_t'(2)) && (c.dr < c.df) && (c.df <= half_of(c.per));
    ref_ok  = !c.cds || ((c.rr < c.rf) && (c.rf < c.dr));
    return base_ok && ref_ok;
  endfunction
endpackage

// File: rtl/cdsclk_cfg.sv
module cdsclk_cfg
  import cdsclk_pkg::*;
#(
  parameter gen_cfg_t DEF = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  gen_cfg_t req,
  output gen_cfg_t staged,
  output logic     err
);
  logic req_ok;
  logic take;

  assign req_ok = cfg_legal(req);
  assign take   = load && req_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= DEF;
      err    <= 1'b0;
    end else if (load) begin
      err <= !req_ok;
      if (take) staged <= req;
    end
  end

  AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !req_ok) |=> ($stable(staged) && err)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(err)); // R9
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !err); // R10
endmodule

// File: rtl/cdsclk_tbase.sv
module cdsclk_tbase
  import cdsclk_pkg::*;
#(
  parameter gen_cfg_t DEF = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  gen_cfg_t staged,
  output gen_cfg_t act,
  output tick_t    sub,
  output slot_t    slot,
  output logic     bnd
);
  logic per_end;

  assign per_end = (sub == (act.per - tick_t'(1)));
  assign bnd     = per_end && (slot == last_slot(act.three));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub  <= '0;
      slot <= '0;
      act  <= DEF;
    end else if (bnd) begin
      sub  <= '0;
      slot <= '0;
      act  <= staged;
    end else if (per_end) begin
      sub  <= '0;
      slot <= slot + slot_t'(1);
    end else begin
      sub  <= sub + tick_t'(1);
    end
  end

  AST_SWAP_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(act)); // R10
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= last_slot(act.three)); // R3
  AST_SUB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sub < act.per); // R3
endmodule

// File: rtl/cdsclk_edges.sv
module cdsclk_edges
  import cdsclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  gen_cfg_t act,
  input  tick_t    sub,
  input  slot_t    slot,
  output logic     ref_o,
  output logic     dat_o,
  output logic     cnv_o,
  output logic     pix_o
);
  logic first_slot;
  logic ref_nx;
  logic dat_nx;
  logic cnv_nx;
  logic pix_nx;

  assign first_slot = (slot == slot_t'(0));
  assign ref_nx = act.cds && first_slot && in_win(sub, act.rr, act.rf);
  assign dat_nx = first_slot && in_win(sub, act.dr, act.df);
  assign cnv_nx = (sub >= half_of(act.per));
  assign pix_nx = first_slot && (sub == act.df);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_o <= 1'b0;
      dat_o <= 1'b0;
      cnv_o <= 1'b0;
      pix_o <= 1'b0;
    end else begin
      ref_o <= ref_nx;
      dat_o <= dat_nx;
      cnv_o <= cnv_nx;
      pix_o <= pix_nx;
    end
  end

  AST_PIX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_o |=> !pix_o); // R7
  AST_PIX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    pix_o |-> (!dat_o && $past(dat_o))); // R7
  AST_REF_DOWN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_o) |-> !ref_o); // R4
  AST_DAT_IN_CNV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dat_o |-> !cnv_o); // R5
endmodule

// File: rtl/cdsclk_gen.sv
module cdsclk_gen
  import cdsclk_pkg::*;
#(
  parameter int unsigned RST_PER = 8,
  parameter int unsigned RST_RR  = 0,
  parameter int unsigned RST_RF  = 1,
  parameter int unsigned RST_DR  = 2,
  parameter int unsigned RST_DF  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              cfg_three,
  input  logic              cfg_cds,
  input  logic [TICK_W-1:0] cfg_period,
  input  logic [TICK_W-1:0] cfg_ref_rise,
  input  logic [TICK_W-1:0] cfg_ref_fall,
  input  logic [TICK_W-1:0] cfg_dat_rise,
  input  logic [TICK_W-1:0] cfg_dat_fall,
  output logic              ref_clk,
  output logic              dat_clk,
  output logic              cnv_clk,
  output logic              pix_start,
  output logic              cfg_err
);
  localparam gen_cfg_t RST_CFG = '{
    three: 1'b1,
    cds:   1'b1,
    per:   tick_t'(RST_PER),
    rr:    tick_t'(RST_RR),
    rf:    tick_t'(RST_RF),
    dr:    tick_t'(RST_DR),
    df:    tick_t'(RST_DF)
  };

  gen_cfg_t req;
  gen_cfg_t staged;
  gen_cfg_t act;
  tick_t    sub;
  slot_t    slot;
  logic     bnd;

  assign req = '{
    three: cfg_three,
    cds:   cfg_cds,
    per:   cfg_period,
    rr:    cfg_ref_rise,
    rf:    cfg_ref_fall,
    dr:    cfg_dat_rise,
    df:    cfg_dat_fall
  };

  cdsclk_cfg #(.DEF(RST_CFG)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .req    (req),
    .staged (staged),
    .err    (cfg_err)
  );

  cdsclk_tbase #(.DEF(RST_CFG)) u_tbase (
    .clk    (clk),
    .rst_n  (rst_n),
    .staged (staged),
    .act    (act),
    .sub    (sub),
    .slot   (slot),
    .bnd    (bnd)
  );

  cdsclk_edges u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .sub   (sub),
    .slot  (slot),
    .ref_o (ref_clk),
    .dat_o (dat_clk),
    .cnv_o (cnv_clk),
    .pix_o (pix_start)
  );

  AST_SHA_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act.cds |=> !ref_clk); // R6
  AST_STAGED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |-> cfg_legal(staged)); // R8
endmodule

// File: tb/tb_cdsclk_gen.sv
module tb_cdsclk_gen;
  localparam int CLK_NS = 10;
  localparam int TW     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic cfg_three = 1'b1;
  logic cfg_cds = 1'b1;
  logic [TW-1:0] cfg_period = 8'd8;
  logic [TW-1:0] cfg_ref_rise = '0;
  logic [TW-1:0] cfg_ref_fall = '0;
  logic [TW-1:0] cfg_dat_rise = '0;
  logic [TW-1:0] cfg_dat_fall = '0;
  logic ref_clk, dat_clk, cnv_clk, pix_start, cfg_err;

  always #(CLK_NS/2) clk = ~clk;

  cdsclk_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_three(cfg_three),
    .cfg_cds(cfg_cds), .cfg_period(cfg_period), .cfg_ref_rise(cfg_ref_rise),
    .cfg_ref_fall(cfg_ref_fall), .cfg_dat_rise(cfg_dat_rise),
    .cfg_dat_fall(cfg_dat_fall), .ref_clk(ref_clk), .dat_clk(dat_clk),
    .cnv_clk(cnv_clk), .pix_start(pix_start), .cfg_err(cfg_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  // model of the setting currently driving the outputs
  bit m_three = 1, m_cds = 1;
  int m_per = 8, m_rr = 0, m_rf = 1, m_dr = 2, m_df = 4;

  logic [3:0] exp_q[$];
  string      cur_tag = "";
  bit         armed = 0;
  bit         running = 0;

  task automatic check(bit ok, string tag, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic bit legal_m(bit cds, int per, int rr, int rf, int dr, int df);
    int v = 0;
    if (per < 2) v++;
    if (df > per / 2) v++;
    if (dr >= df) v++;
    if (cds && rf >= dr) v++;
    if (cds && rr >= rf) v++;
    return v == 0;
  endfunction

  // monitor: compares each cycle against the queue once aligned on pix_start
  always @(negedge clk) begin
    if (armed) begin
      if (!running && pix_start) running = 1;
      if (running && exp_q.size() > 0) begin
        logic [3:0] e;
        logic [3:0] g;
        e = exp_q.pop_front();
        g = {ref_clk, dat_clk, cnv_clk, pix_start};
        check(g == e, cur_tag, int'(g), int'(e));
        if (exp_q.size() == 0) begin
          running = 0;
          armed = 0;
        end
      end
    end
  end

  task automatic wait_pix(int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (pix_start) seen++;
    end
  endtask

  // driver: pushes whole pixels of expected {ref,dat,cnv,pix}, starting at pix_start
  task automatic run_pixels(int npix, string tag);
    int len;
    len = m_per * (m_three ? 3 : 1);
    wait_pix(2);
    @(negedge clk);
    for (int u = 0; u < npix * len; u++) begin
      int t, c, s;
      logic r, d, k, p;
      t = (m_df + u) % len;
      c = t / m_per;
      s = t % m_per;
      r = m_cds && c == 0 && s >= m_rr && s < m_rf;
      d = c == 0 && s >= m_dr && s < m_df;
      k = s >= m_per / 2;
      p = c == 0 && s == m_df;
      exp_q.push_back({r, d, k, p});
    end
    cur_tag = tag;
    armed = 1;
    while (armed) @(negedge clk);
  endtask

  task automatic load_cfg(bit three, bit cds, int per, int rr, int rf, int dr, int df);
    bit ok;
    ok = legal_m(cds, per, rr, rf, dr, df);
    @(negedge clk);
    cfg_three = three; cfg_cds = cds;
    cfg_period = TW'(per); cfg_ref_rise = TW'(rr); cfg_ref_fall = TW'(rf);
    cfg_dat_rise = TW'(dr); cfg_dat_fall = TW'(df);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    if (ok) check(cfg_err == 1'b0, "R8 R10 cfg_err after accepted load", int'(cfg_err), 0);
    else    check(cfg_err == 1'b1, "R8 R9 cfg_err after refused load", int'(cfg_err), 1);
    if (ok) begin
      m_three = three; m_cds = cds; m_per = per;
      m_rr = rr; m_rf = rf; m_dr = dr; m_df = df;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog: got %0d cycles expected fewer", 100000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int first_pix;
    // R1: quiet outputs during reset
    repeat (3) begin
      @(negedge clk);
      check({ref_clk, dat_clk, cnv_clk, pix_start, cfg_err} == 5'b0,
            "R1 outputs in reset", int'({ref_clk, dat_clk, cnv_clk, pix_start, cfg_err}), 0);
    end
    rst_n = 1'b1;
    // R2: fresh pixel from tick 0; tick k shows after edge k+1
    @(negedge clk);
    check(ref_clk == 1'b1, "R2 ref_clk after first edge", int'(ref_clk), 1);
    check({dat_clk, cnv_clk} == 2'b00, "R2 dat/cnv after first edge", int'({dat_clk, cnv_clk}), 0);
    first_pix = 1;
    while (!pix_start && first_pix < 20) begin
      @(negedge clk);
      first_pix++;
    end
    check(first_pix == 5, "R2 first pix_start edge", first_pix, 5);

    // built-in setting: three-channel, double sampling
    run_pixels(2, "R3/R4/R5/R7 default three-channel");

    // one-channel double sampling
    load_cfg(0, 1, 6, 0, 1, 2, 3);
    run_pixels(3, "R3/R4/R5/R7/R10 one-channel cds");

    // three-channel sample-and-hold, reference fields meaningless
    load_cfg(1, 0, 10, 7, 2, 1, 5);
    run_pixels(2, "R3/R5/R6/R10 three-channel sha");

    // refused: reference fall not before data rise
    load_cfg(1, 1, 8, 0, 2, 2, 4);
    run_pixels(2, "R9 refused keeps sha timing");
    check(cfg_err == 1'b1, "R9 cfg_err held", int'(cfg_err), 1);

    // refused: data fall after converter rise
    load_cfg(0, 1, 6, 0, 1, 2, 4);
    // refused: period too short
    load_cfg(0, 0, 1, 0, 0, 0, 1);
    run_pixels(1, "R9 still previous timing");

    // smallest legal one-channel sample-and-hold
    load_cfg(0, 0, 2, 0, 0, 0, 1);
    run_pixels(4, "R3/R6/R7/R10 minimal period");

    // odd period, data fall on converter rise tick
    load_cfg(1, 1, 9, 1, 2, 3, 4);
    run_pixels(2, "R3/R4/R5/R7/R10 odd period");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule